// File: doc/BRIEF.md
# Pattern-Fill and Pixel-Copy Write Engine

This block speeds up drawing into an 8-bit-per-pixel framebuffer. A host sends memory-mapped commands over a valid/ready command stream. The bus address of each command selects one of four windows and also carries a destination pixel address. The engine then runs the pixel memory one access per cycle through a single-port synchronous interface. There are four kinds of command:

- A colour write loads the fill colour.
- A pattern write lays that colour into up to 32 consecutive pixels, one pixel for each set bit of a 32-bit pattern.
- A run write copies 1 to 32 pixels from a source pixel address to the destination.
- The same run write fills the run with the colour when its source field is all ones.

Back-pressure rules: a command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low for every cycle that `busy` is high. A host holding `cmd_valid` keeps its command and fields stable until the transfer. Reads transfer under the same rule and are answered with zero data on `rsp_valid` one cycle later. There is no way to stall the response.

Top module: `pxaccel_engine`

## Requirements
- R1: After a synchronous reset, `busy` and `rsp_valid` are 0, `cmd_ready` is 1, `mem_req` is 0 and the colour register holds 0.
- R2: `cmd_addr[25:24]` selects the window: 0 is colour, 1 is pattern, 2 is run, 3 is no effect. A write to window 3 causes no memory access, no busy cycle and no colour change. The destination pixel address is `cmd_addr[3 +: PIX_AW]`.
- R3: A pattern write makes the engine busy for exactly 32 cycles. In cycle i (0..31) it writes the colour to destination+i only if data bit 31-i is 1. A zero bit makes no access, so that pixel is left unchanged.
- R4: For a run write, the run length is `cmd_data[28:24]` + 1, which gives 1 to 32 pixels.
- R5: If `cmd_data[23:0]` is 0xFFFFFF, the run is a fill. The engine writes the colour to destination+i, for i counting up, one pixel per cycle, and is busy for exactly length cycles.
- R6: Any other source value is a copy from source = `cmd_data[PIX_AW-1:0]`. For each i counting up, the engine reads source+i in one cycle and writes that data to destination+i in the next cycle. A copy is busy for 2 × length cycles, so overlapping forward copies behave as ascending byte copies.
- R7: A read transfer in any window produces `rsp_valid`=1 with `rsp_data`=0 exactly one cycle later. At all other times `rsp_valid` is 0.
- R8: `busy` rises in the cycle after a pattern or run write is accepted. While `busy` is high, `cmd_ready` is 0 and no command is taken.
- R9: A write to window 0 loads `cmd_data[7:0]` as the colour. The colour keeps its value across pattern, fill and copy operations.
- R10: Destination and source pixel addresses wrap modulo 2^PIX_AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine can accept a command |
| cmd_we | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Bus address (window and pixel) |
| cmd_data | input | 32 | Write data |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | 32 | Read response data (always zero) |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Pixel memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | PIX_AW | Pixel address |
| mem_wdata | output | PIX_W | Pixel write data |
| mem_rdata | input | PIX_W | Read data, valid the cycle after a read access |

## Verification
The first pixel access of an operation appears in the cycle right after the accepting edge. Each following access comes one cycle later, with two cycles per pixel for a copy. A read response is due one cycle after it is accepted. The bench model turns every accepted command into a queue with one expected entry per cycle. At each falling edge it pops exactly one entry and compares it with `mem_req`, `mem_we`, `mem_addr`, `mem_wdata`, `busy` and `cmd_ready`. So a missing, extra or shifted access shows up in the exact cycle where it goes wrong. Copy data is predicted from a reference pixel array that is updated in the same ascending order.

// File: rtl/pxa_pkg.sv
package pxa_pkg;
  typedef enum logic [1:0] {
    WIN_COLOUR = 2'd0,
    WIN_PATTERN = 2'd1,
    WIN_RUN = 2'd2,
    WIN_NONE = 2'd3
  } win_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAT,
    ST_FILL,
    ST_CRD,
    ST_CWR
  } st_e;

  localparam int DATA_W = 32;
  localparam int SRC_FIELD_W = 24;
endpackage

// File: rtl/pxa_decode.sv
module pxa_decode
  import pxa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PIX_AW = 20,
  parameter int LEN_W = 5,
  parameter int WIN_LSB = 24
) (
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  output win_e              win,
  output logic [PIX_AW-1:0] dst_pix,
  output logic [PIX_AW-1:0] src_pix,
  output logic [LEN_W-1:0]  len_m1,
  output logic              is_fill
);
  logic unused_dec;

  assign win     = win_e'(cmd_addr[WIN_LSB +: 2]);
  assign dst_pix = cmd_addr[3 +: PIX_AW];
  assign src_pix = cmd_data[PIX_AW-1:0];
  assign len_m1  = cmd_data[SRC_FIELD_W +: LEN_W];
  assign is_fill = &cmd_data[SRC_FIELD_W-1:0];
  assign unused_dec = ^{cmd_addr, cmd_data};
endmodule

// File: rtl/pxa_pattern_shift.sv
module pxa_pattern_shift #(
  parameter int PAT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             shift,
  input  logic [PAT_W-1:0] pat_in,
  output logic             bit_now
);
  logic [PAT_W-1:0] pat_q;

  always_ff @(posedge clk) begin
    if (rst) pat_q <= '0;
    else if (load) pat_q <= pat_in;
    else if (shift) pat_q <= {pat_q[PAT_W-2:0], 1'b0};
  end

  assign bit_now = pat_q[PAT_W-1];
endmodule

// File: rtl/pxa_run_ctr.sv
module pxa_run_ctr #(
  parameter int PIX_AW = 20,
  parameter int LEN_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [PIX_AW-1:0] dst_in,
  input  logic [PIX_AW-1:0] src_in,
  input  logic [LEN_W-1:0]  rem_in,
  output logic [PIX_AW-1:0] dst_cur,
  output logic [PIX_AW-1:0] src_cur,
  output logic              last
);
  logic [LEN_W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dst_cur <= '0;
      src_cur <= '0;
      rem_q   <= '0;
    end else if (load) begin
      dst_cur <= dst_in;
      src_cur <= src_in;
      rem_q   <= rem_in;
    end else if (step) begin
      dst_cur <= dst_cur + 1'b1;
      src_cur <= src_cur + 1'b1;
      rem_q   <= rem_q - 1'b1;
    end
  end

  assign last = (rem_q == '0);
endmodule

// File: rtl/pxaccel_engine.sv
module pxaccel_engine
  import pxa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PIX_AW = 20,
  parameter int PIX_W = 8,
  parameter int PAT_W = 32,
  parameter int WIN_LSB = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_we,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [31:0]       cmd_data,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PIX_AW-1:0] mem_addr,
  output logic [PIX_W-1:0]  mem_wdata,
  input  logic [PIX_W-1:0]  mem_rdata
);
  localparam int LEN_W = $clog2(PAT_W);

  st_e               state;
  logic [PIX_W-1:0]  colour_q;
  win_e              win;
  logic [PIX_AW-1:0] dst_pix, src_pix, dst_cur, src_cur;
  logic [LEN_W-1:0]  len_m1, rem_ld;
  logic              is_fill, last, pat_bit;
  logic              accept, wr_acc, start_op, step;

  assign accept   = cmd_valid && cmd_ready;
  assign wr_acc   = accept && cmd_we;
  assign start_op = wr_acc && (win == WIN_PATTERN || win == WIN_RUN);
  assign step     = (state == ST_PAT) || (state == ST_FILL) || (state == ST_CWR);
  assign rem_ld   = (win == WIN_PATTERN) ? LEN_W'(PAT_W - 1) : len_m1;

  pxa_decode #(
    .ADDR_W(ADDR_W), .PIX_AW(PIX_AW), .LEN_W(LEN_W), .WIN_LSB(WIN_LSB)
  ) u_dec (
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .win(win), .dst_pix(dst_pix),
    .src_pix(src_pix), .len_m1(len_m1), .is_fill(is_fill)
  );

  pxa_pattern_shift #(.PAT_W(PAT_W)) u_pat (
    .clk(clk), .rst(rst), .load(wr_acc && win == WIN_PATTERN),
    .shift(state == ST_PAT), .pat_in(cmd_data[PAT_W-1:0]), .bit_now(pat_bit)
  );

  pxa_run_ctr #(.PIX_AW(PIX_AW), .LEN_W(LEN_W)) u_run (
    .clk(clk), .rst(rst), .load(start_op), .step(step), .dst_in(dst_pix),
    .src_in(src_pix), .rem_in(rem_ld), .dst_cur(dst_cur), .src_cur(src_cur),
    .last(last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      colour_q  <= '0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= accept && !cmd_we;
      case (state)
        ST_IDLE: begin
          if (wr_acc) begin
            case (win)
              WIN_COLOUR:  colour_q <= cmd_data[PIX_W-1:0];
              WIN_PATTERN: state <= ST_PAT;
              WIN_RUN:     state <= is_fill ? ST_FILL : ST_CRD;
              default:     state <= ST_IDLE;
            endcase
          end
        end
        ST_PAT:  if (last) state <= ST_IDLE;
        ST_FILL: if (last) state <= ST_IDLE;
        ST_CRD:  state <= ST_CWR;
        ST_CWR:  state <= last ? ST_IDLE : ST_CRD;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = dst_cur;
    mem_wdata = colour_q;
    case (state)
      ST_PAT:  begin mem_req = pat_bit; mem_we = 1'b1; end
      ST_FILL: begin mem_req = 1'b1;    mem_we = 1'b1; end
      ST_CRD:  begin mem_req = 1'b1;    mem_addr = src_cur; end
      ST_CWR:  begin mem_req = 1'b1;    mem_we = 1'b1; mem_wdata = mem_rdata; end
      default: ;
    endcase
  end

  assign busy      = (state != ST_IDLE);
  assign cmd_ready = !busy;
  assign rsp_data  = '0;

  a_r3_pat_addr_step: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PAT && $past(state == ST_PAT)) |-> mem_addr == $past(mem_addr) + 1'b1);
  a_r6_read_then_write: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |=> (mem_req && mem_we));
  a_r7_rsp_after_read: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(cmd_valid && cmd_ready && !cmd_we));
  a_r8_start_needs_accept: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cmd_valid && cmd_ready && cmd_we));
  a_r9_colour_hold: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(colour_q));
endmodule

// File: tb/pxaccel_engine_test.sv
module pxaccel_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int PA = 12;
  localparam int MEMN = 1 << PA;

  typedef struct packed {
    logic          req;
    logic          we;
    logic [PA-1:0] addr;
    logic          from_mem;
    logic [PA-1:0] sa;
    logic [3:0]    rq;
  } op_t;

  logic clk = 0, rst = 1;
  logic cmd_valid = 0, cmd_we = 0;
  logic [31:0] cmd_addr = 0, cmd_data = 0;
  logic cmd_ready, rsp_valid, busy, mem_req, mem_we;
  logic [31:0] rsp_data;
  logic [PA-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  logic [7:0] bmem [MEMN];
  logic [7:0] ref_mem [MEMN];
  logic [7:0] ref_col = 0;
  op_t q[$];
  int total = 0, bad = 0;
  logic hs_q = 0, cap_we = 0;
  logic [31:0] cap_addr = 0, cap_data = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pxaccel_engine #(.PIX_AW(PA)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial begin
    for (int i = 0; i < MEMN; i++) begin
      bmem[i] = 8'(i) ^ 8'h5A;
      ref_mem[i] = 8'(i) ^ 8'h5A;
    end
    mem_rdata = 0;
  end

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) bmem[mem_addr] <= mem_wdata;
      else mem_rdata <= bmem[mem_addr];
    end
    hs_q <= !rst && cmd_valid && cmd_ready;
    cap_we <= cmd_we;
    cap_addr <= cmd_addr;
    cap_data <= cmd_data;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic op_t mk(input logic rqq, input logic w, input logic [PA-1:0] a,
                             input logic fm, input logic [PA-1:0] s, input logic [3:0] r);
    op_t o;
    o.req = rqq; o.we = w; o.addr = a; o.from_mem = fm; o.sa = s; o.rq = r;
    return o;
  endfunction

  // Reference model: one queue entry per expected busy cycle.
  always @(negedge clk) begin
    if (!rst) begin
      if (hs_q && cap_we) begin
        logic [PA-1:0] pix;
        logic [PA-1:0] src;
        int len;
        pix = cap_addr[3 +: PA];
        src = cap_data[PA-1:0];
        len = int'(cap_data[28:24]) + 1;
        case (cap_addr[25:24])
          2'd0: ref_col = cap_data[7:0];                       // R9
          2'd1: for (int i = 0; i < 32; i++)                     // R3
                  q.push_back(mk(cap_data[31-i], 1'b1, pix + PA'(i), 1'b0, '0, 4'd3));
          2'd2: begin                                            // R4
            if (cap_data[23:0] == 24'hFFFFFF)                    // R5
              for (int i = 0; i < len; i++)
                q.push_back(mk(1'b1, 1'b1, pix + PA'(i), 1'b0, '0, 4'd5));
            else
              for (int i = 0; i < len; i++) begin                // R6
                q.push_back(mk(1'b1, 1'b0, src + PA'(i), 1'b0, '0, 4'd6));
                q.push_back(mk(1'b1, 1'b1, pix + PA'(i), 1'b1, src + PA'(i), 4'd6));
              end
          end
          default: ;                                             // R2: window 3
        endcase
      end
      // R7: read response one cycle after a read transfer
      if (hs_q && !cap_we) begin
        chk(rsp_valid === 1'b1, "R7 rsp_valid", rsp_valid, 1);
        chk(rsp_data === 32'h0, "R7 rsp_data", rsp_data, 0);
      end else chk(rsp_valid === 1'b0, "R7 no rsp", rsp_valid, 0);
      if (q.size() > 0) begin
        op_t e;
        string tg;
        e = q.pop_front();
        tg = $sformatf("R%0d", e.rq);
        chk(busy === 1'b1 && cmd_ready === 1'b0, "R8 busy/ready", {busy, cmd_ready}, 2'b10);
        chk(mem_req === e.req, {tg, " mem_req"}, mem_req, e.req);
        if (e.req) begin
          chk(mem_we === e.we, {tg, " mem_we"}, mem_we, e.we);
          chk(mem_addr === e.addr, {tg, " mem_addr"}, mem_addr, e.addr);
          if (e.we) begin
            logic [7:0] ev;
            ev = e.from_mem ? ref_mem[e.sa] : ref_col;
            chk(mem_wdata === ev, {tg, " mem_wdata"}, mem_wdata, ev);
            ref_mem[e.addr] = ev;
          end
        end
      end else begin
        chk(busy === 1'b0 && cmd_ready === 1'b1, "R8 idle", {busy, cmd_ready}, 2'b01);
        chk(mem_req === 1'b0, "R2 idle no access", mem_req, 0);
      end
    end
  end

  task automatic send(input logic w, input logic [1:0] win, input int pix, input logic [31:0] d);
    bit t;
    cmd_valid = 1; cmd_we = w;
    cmd_addr = (32'(win) << 24) | (32'(pix) << 3);
    cmd_data = d;
    do begin
      t = cmd_ready;
      @(negedge clk);
    end while (!t);
    cmd_valid = 0;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy === 0 && cmd_ready === 1 && mem_req === 0 && rsp_valid === 0, "R1 reset outputs",
        {busy, cmd_ready, mem_req, rsp_valid}, 4'b0100);
    rst = 0;
    @(negedge clk);
    // R1/R9: colour is 0 after reset, seen through a fill
    send(1, 2'd2, 40, 32'h01FF_FFFF);
    send(1, 2'd0, 0, 32'hFFFF_FFA5);                    // R9 colour load
    send(1, 2'd1, 16, 32'h8000_0001);                   // R3 end bits
    send(1, 2'd1, 60, 32'hF0F0_1234);                   // R3 mixed
    send(1, 2'd2, 100, 32'h04FF_FFFF);                  // R5 fill len 5
    send(1, 2'd2, 200, 32'h0700_0010);                  // R6 copy len 8
    send(1, 2'd2, 202, 32'h0500_00C8);                  // R6 overlap forward
    send(1, 2'd2, 300, 32'h1F00_0400);                  // R4 len 32 copy
    send(1, 2'd2, 350, 32'h00FF_FFFF);                  // R4 len 1 fill
    send(1, 2'd2, 360, 32'h02F0_0010);                  // R6 low source bits used
    send(1, 2'd3, 500, 32'h0000_0011);                  // R2 window 3 ignored
    send(1, 2'd2, 510, 32'h01FF_FFFF);                  // R2/R9 colour still A5
    send(0, 2'd1, 5, 32'h0);                            // R7 reads
    send(0, 2'd2, 6, 32'h0);
    send(0, 2'd0, 7, 32'h0);
    send(1, 2'd0, 0, 32'h0000_003C);
    send(1, 2'd1, MEMN - 6, 32'hFFFF_FFFF);             // R10 wrap
    send(1, 2'd2, MEMN - 2, 32'h0300_0FFE);             // R10 copy wrap
    while (q.size() > 0 || busy) @(negedge clk);
    repeat (2) @(negedge clk);
    begin
      int mism = 0;
      for (int i = 0; i < MEMN; i++) if (bmem[i] !== ref_mem[i]) mism++;
      chk(mism == 0, "R3 final memory image", mism, 0);
    end
    finish_run();
  end
endmodule